// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-ported memory and watches the enable and address that each side, left and right, presents on every clock. When both sides are enabled on the same location, it lets one of them continue and raises an active-low busy flag toward the other. Whoever already held the location keeps it. If both arrive in the same cycle, the left side wins. The decision uses only enables and addresses and ignores whether either side reads or writes.

Each side's write enable passes through the block. It is gated off while that side's busy is active, so a losing write never reaches the array. A mode pin picks the role of the part. In master mode the part arbitrates and drives its busy outputs. In slave mode the part takes busy from an external arbiter and uses it only to inhibit writes. A combined active-high flag reports that either side is busy and can serve as an error or interrupt source.

Top module: `dpc_arbiter`

## Requirements
- R1: In master mode a busy output goes low only in the cycle after a clock edge at which both enables were high and both addresses were equal.
- R2: In master mode, one cycle after a clock edge at which the two enabled addresses were equal, exactly one of `l_busy_n` and `r_busy_n` is low.
- R3: The write enables `l_we` and `r_we` have no effect on the busy outputs. A collision of two reads flags the same side as a collision of two writes.
- R4: `l_we_gated` equals `l_we` while the left side is not busy and is 0 while it is busy. The same rule holds for the right side.
- R5: If both sides reach the same address in the same cycle, meaning neither was enabled on that address at the previous edge, the left side wins and `r_busy_n` goes low.
- R6: A side that was already enabled on an address at the previous edge keeps priority over a side that newly arrives there. The newcomer stays busy for as long as the collision lasts.
- R7: Busy returns high in the cycle after the winner disables or moves to another address.
- R8: In slave mode both busy outputs are held high. The inputs `l_busy_in_n` and `r_busy_in_n` (active low) act only as write inhibits for their own side.
- R9: `any_busy` is high exactly when at least one side is busy. That side's busy is the registered arbitration result in master mode and the busy input in slave mode.
- R10: While reset is held and after its release with both sides idle, both busy outputs are high, `any_busy` is 0 and both gated write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 = arbitrate (master), 0 = take busy from outside (slave) |
| l_en | input | 1 | Left side enable, active high |
| l_addr | input | ADDR_W | Left side address |
| l_we | input | 1 | Left side write request |
| r_en | input | 1 | Right side enable, active high |
| r_addr | input | ADDR_W | Right side address |
| r_we | input | 1 | Right side write request |
| l_busy_in_n | input | 1 | Left busy from an external arbiter, used in slave mode |
| r_busy_in_n | input | 1 | Right busy from an external arbiter, used in slave mode |
| l_busy_n | output | 1 | Left busy, active low, registered |
| r_busy_n | output | 1 | Right busy, active low, registered |
| l_we_gated | output | 1 | Left write enable after busy gating |
| r_we_gated | output | 1 | Right write enable after busy gating |
| any_busy | output | 1 | OR of both sides' busy, active high |

## Verification
Two functions can fall in the same cycle: a side's write request and its busy. The bench provokes this by having the losing side hold a write while a collision persists, with directed sequences and with random traffic confined to four addresses so that collisions are frequent. A reference model in the bench tracks each side's previous enable and address and the last winner. After every clock edge the bench judges the busy outputs, the gated write enables and the combined flag against that model. In slave mode it checks that random busy inputs strip exactly the writes of their own side.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    typedef struct packed {
        side_e winner;
        logic  busy_l;
        logic  busy_r;
    } arb_state_t;

endpackage

// File: rtl/dpc_port_track.sv
module dpc_port_track #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              held
);

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        trk_d.en   = en;
        trk_d.addr = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // held: this side was already enabled on the same address at the last edge
    assign held = en && trk_q.en && (trk_q.addr == addr);

endmodule

// File: rtl/dpc_winner.sv
module dpc_winner
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_held,
    input  logic              r_held,
    output logic              busy_l,
    output logic              busy_r
);

    arb_state_t st_d, st_q;
    logic       clash;
    side_e      pick;

    always_comb begin
        clash = l_en && r_en && (l_addr == r_addr);
        // incumbent keeps priority; fresh tie goes to the left side
        if (l_held && !r_held) begin
            pick = SIDE_L;
        end else if (r_held && !l_held) begin
            pick = SIDE_R;
        end else if (l_held && r_held) begin
            pick = st_q.winner;
        end else begin
            pick = SIDE_L;
        end

        st_d = st_q;
        if (clash) begin
            st_d.winner = pick;
        end
        st_d.busy_l = clash && (pick == SIDE_R);
        st_d.busy_r = clash && (pick == SIDE_L);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{winner: SIDE_L, busy_l: 1'b0, busy_r: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_l = st_q.busy_l;
    assign busy_r = st_q.busy_r;

endmodule

// File: rtl/dpc_wr_gate.sv
module dpc_wr_gate (
    input  logic mode_master,
    input  logic we,
    input  logic busy_arb,
    input  logic busy_ext_n,
    output logic busy_n_o,
    output logic busy_eff,
    output logic we_o
);

    always_comb begin
        if (mode_master) begin
            busy_eff = busy_arb;
            busy_n_o = ~busy_arb;
        end else begin
            busy_eff = ~busy_ext_n;
            busy_n_o = 1'b1;
        end
        we_o = we && !busy_eff;
    end

endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_master,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_we,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_we_gated,
    output logic              r_we_gated,
    output logic              any_busy
);

    localparam int NSIDE = 2;

    logic              en_a      [NSIDE];
    logic [ADDR_W-1:0] addr_a    [NSIDE];
    logic              we_a      [NSIDE];
    logic              ext_n_a   [NSIDE];
    logic              held_a    [NSIDE];
    logic              barb_a    [NSIDE];
    logic              bout_n_a  [NSIDE];
    logic              beff_a    [NSIDE];
    logic              weo_a     [NSIDE];

    assign en_a[0]    = l_en;
    assign en_a[1]    = r_en;
    assign addr_a[0]  = l_addr;
    assign addr_a[1]  = r_addr;
    assign we_a[0]    = l_we;
    assign we_a[1]    = r_we;
    assign ext_n_a[0] = l_busy_in_n;
    assign ext_n_a[1] = r_busy_in_n;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dpc_port_track #(.ADDR_W(ADDR_W)) i_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_a[g]),
            .addr  (addr_a[g]),
            .held  (held_a[g])
        );

        dpc_wr_gate i_gate (
            .mode_master (mode_master),
            .we          (we_a[g]),
            .busy_arb    (barb_a[g]),
            .busy_ext_n  (ext_n_a[g]),
            .busy_n_o    (bout_n_a[g]),
            .busy_eff    (beff_a[g]),
            .we_o        (weo_a[g])
        );
    end

    dpc_winner #(.ADDR_W(ADDR_W)) i_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_en   (l_en),
        .l_addr (l_addr),
        .r_en   (r_en),
        .r_addr (r_addr),
        .l_held (held_a[0]),
        .r_held (held_a[1]),
        .busy_l (barb_a[0]),
        .busy_r (barb_a[1])
    );

    assign l_busy_n   = bout_n_a[0];
    assign r_busy_n   = bout_n_a[1];
    assign l_we_gated = weo_a[0];
    assign r_we_gated = weo_a[1];
    assign any_busy   = beff_a[0] || beff_a[1];

endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_master,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_we,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_we,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_we_gated,
    input logic              r_we_gated,
    input logic              any_busy
);

    logic same_now;
    assign same_now = l_en && r_en && (l_addr == r_addr);

    p_busy_needs_clash_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_master && $past(mode_master) && (!l_busy_n || !r_busy_n)
        |-> $past(same_now));

    p_one_loser_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~l_busy_n, ~r_busy_n}));

    p_clash_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_master && same_now |=> !mode_master || (l_busy_n ^ r_busy_n));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_master && !same_now |=> l_busy_n && r_busy_n);

    p_gate_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l_we_gated |-> l_we && (mode_master ? l_busy_n : l_busy_in_n));

    p_gate_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_we_gated |-> r_we && (mode_master ? r_busy_n : r_busy_in_n));

    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master |-> l_busy_n && r_busy_n);

    p_slave_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master |-> any_busy == (!l_busy_in_n || !r_busy_in_n));

    p_master_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_master |-> any_busy == (!l_busy_n || !r_busy_n));

endmodule

bind dpc_arbiter dpc_arbiter_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_dpc_arbiter.sv
module test_dpc_arbiter;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_master = 1'b1;
    logic          l_en = 1'b0, r_en = 1'b0, l_we = 1'b0, r_we = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic          l_busy_n, r_busy_n, l_we_gated, r_we_gated, any_busy;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // reference model state
    logic          m_le = 1'b0, m_re = 1'b0;
    logic [AW-1:0] m_la = '0, m_ra = '0;
    logic          m_win = 1'b0;    // 0 = left, 1 = right
    logic          e_bl = 1'b0, e_br = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dpc_arbiter #(.ADDR_W(AW)) i_dpc_arbiter (.*);

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // model update for one edge, from the requirements (R1, R5, R6, R7)
    function automatic void model_edge();
        logic clash, lh, rh, w;
        clash = l_en && r_en && (l_addr == r_addr);
        lh = l_en && m_le && (m_la == l_addr);
        rh = r_en && m_re && (m_ra == r_addr);
        if (lh && !rh)      w = 1'b0;
        else if (rh && !lh) w = 1'b1;
        else if (lh && rh)  w = m_win;
        else                w = 1'b0;
        if (clash) m_win = w;
        e_bl = clash && w;
        e_br = clash && !w;
        m_le = l_en; m_la = l_addr;
        m_re = r_en; m_ra = r_addr;
    endfunction

    task automatic step(input logic le, input logic [AW-1:0] la, input logic lw,
                        input logic re, input logic [AW-1:0] ra, input logic rw,
                        input string tag);
        @(negedge clk);
        l_en = le; l_addr = la; l_we = lw;
        r_en = re; r_addr = ra; r_we = rw;
        model_edge();
        @(posedge clk);
        #1;
        if (mode_master) begin
            check({tag, " l_busy_n"}, l_busy_n, !e_bl);
            check({tag, " r_busy_n"}, r_busy_n, !e_br);
            check({tag, " R4 l_we_gated"}, l_we_gated, lw && !e_bl);
            check({tag, " R4 r_we_gated"}, r_we_gated, rw && !e_br);
            check({tag, " R9 any_busy"}, any_busy, e_bl || e_br);
        end else begin
            check({tag, " R8 l_busy_n"}, l_busy_n, 1'b1);
            check({tag, " R8 r_busy_n"}, r_busy_n, 1'b1);
            check({tag, " R8 l_we_gated"}, l_we_gated, lw && l_busy_in_n);
            check({tag, " R8 r_we_gated"}, r_we_gated, rw && r_busy_in_n);
            check({tag, " R9 any_busy"}, any_busy, !l_busy_in_n || !r_busy_in_n);
        end
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "idle");
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset l_busy_n", l_busy_n, 1'b1);
        check("R10 reset r_busy_n", r_busy_n, 1'b1);
        check("R10 reset any_busy", any_busy, 1'b0);
        check("R10 reset we_gated", {l_we_gated, r_we_gated}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        check("R10 after release", {l_busy_n, r_busy_n, any_busy}, 3'b110);

        // R1: different addresses never collide
        step(1'b1, 11'h7fe, 1'b1, 1'b1, 11'h7ff, 1'b1, "R1 distinct");
        check("R1 no busy", {l_busy_n, r_busy_n}, 2'b11);
        idle();

        // R5: simultaneous arrival, both reads, left wins
        step(1'b1, 11'h123, 1'b0, 1'b1, 11'h123, 1'b0, "R5 tie reads");
        check("R5 right loses", {l_busy_n, r_busy_n}, 2'b10);
        idle();
        // R3: same tie with writes flags the same side
        step(1'b1, 11'h123, 1'b1, 1'b1, 11'h123, 1'b1, "R3 tie writes");
        check("R3 same loser", {l_busy_n, r_busy_n}, 2'b10);
        check("R4 right write stripped", {l_we_gated, r_we_gated}, 2'b10);
        idle();

        // R6: right holds first, left arrives and loses while collision lasts
        step(1'b0, '0, 1'b0, 1'b1, 11'h055, 1'b0, "R6 right alone");
        step(1'b1, 11'h055, 1'b1, 1'b1, 11'h055, 1'b0, "R6 left arrives");
        check("R6 left loses", {l_busy_n, r_busy_n}, 2'b01);
        step(1'b1, 11'h055, 1'b1, 1'b1, 11'h055, 1'b1, "R6 persists");
        check("R6 still left busy", {l_busy_n, r_busy_n}, 2'b01);
        check("R4 left write gated", l_we_gated, 1'b0);
        // R7: winner moves away, busy released next cycle
        step(1'b1, 11'h055, 1'b1, 1'b1, 11'h056, 1'b1, "R7 winner moves");
        check("R7 released", {l_busy_n, r_busy_n}, 2'b11);
        check("R7 left write passes", l_we_gated, 1'b1);
        idle();

        // R7: winner disables
        step(1'b1, 11'h200, 1'b0, 1'b1, 11'h200, 1'b0, "R7 clash");
        step(1'b0, 11'h200, 1'b0, 1'b1, 11'h200, 1'b1, "R7 winner off");
        check("R7 released on disable", {l_busy_n, r_busy_n}, 2'b11);
        idle();

        // random traffic in master mode, small address range
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, AW'($urandom % 4), 1'($urandom),
                 ($urandom % 4) != 0, AW'($urandom % 4), 1'($urandom), "R2 R6 random");
        end
        idle();

        // slave mode
        @(negedge clk);
        mode_master = 1'b0;
        l_busy_in_n = 1'b0; r_busy_in_n = 1'b1;
        step(1'b1, 11'h010, 1'b1, 1'b1, 11'h010, 1'b1, "R8 left inhibited");
        check("R8 left stripped only", {l_we_gated, r_we_gated}, 2'b01);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            l_busy_in_n = 1'($urandom);
            r_busy_in_n = 1'($urandom);
            step(1'($urandom), AW'($urandom % 4), 1'($urandom),
                 1'($urandom), AW'($urandom % 4), 1'($urandom), "R8 R9 random");
        end
        @(negedge clk);
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
        idle();
        @(negedge clk);
        mode_master = 1'b1;
        idle();
        idle();
        step(1'b1, 11'h3a, 1'b0, 1'b1, 11'h3a, 1'b0, "R5 back in master");
        check("R5 master again", {l_busy_n, r_busy_n}, 2'b10);
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule